// File: doc/BRIEF.md
# SPI Master Frame Sequencer

The block turns words taken from a transmit queue into serial frames and assembles the bits it reads back into words for a receive queue. Clock polarity, clock phase, word length (4 to 16 bits, most significant bit first) and the serial clock rate can all be chosen at run time. The sequencer drives the serial clock, an active-low frame select and the outgoing data line, and it samples the incoming data line. All of its outputs come from registers.

A frame begins only when the block is enabled and the transmit queue reports a word. The sequencer pops that word with a one-cycle strobe, pulls frame select low and steps through the frame in half-period units of the serial clock. In phase-0 mode every word is a frame of its own, and consecutive words are separated by a one-period high pulse on frame select. In phase-1 mode frame select stays low and the clock keeps running from one word to the next while words remain. The configuration is captured when a stream of words begins and is held until the stream ends.

Top module: `spi_frame_seq`

## Requirements
- R1: Out of reset and while idle, `sck` equals `clk_pol`, `sel_n` is 1, `sdo` is 0 and `busy` is 0.
- R2: A frame starts (`sel_n` falls) only while `enable` is 1 and `tx_avail` is 1. Each word is taken by a `tx_pop` pulse exactly one cycle wide. With `enable` at 0, no word is popped and `sel_n` stays high.
- R3: Let H be the half period of R9. In phase 0 (`clk_pha`=0), the MSB appears on `sdo` H cycles after `sel_n` falls. In both phases the first `sck` edge comes 2H cycles after `sel_n` falls.
- R4: The leading edge is the first edge away from the rest level `clk_pol`. In phase 0, `sdi` and `sdo` are sampled on leading edges and `sdo` changes on trailing edges. In phase 1, `sdo` changes on leading edges and sampling happens on trailing edges.
- R5: After the last sample of a stream, `sel_n` returns high 2H cycles later, with `sck` at its rest level.
- R6: In phase 0, when further words are available, `sel_n` goes high for exactly 2H cycles between consecutive words.
- R7: The frame length is `len_m1`+1 bits, and `len_m1` values below 3 are treated as 3. Bits are sent MSB first (bit `len_m1` of `tx_word`). A frame has exactly two `sck` edges per bit.
- R8: In phase 1, back-to-back words are sent with `sel_n` held low throughout (one fall per stream) and with an even clock.
- R9: Every `sck` edge within a frame is H = `half_div`+1 cycles after the previous one, so the serial period is 2H. A `half_div` of 0 is treated as 1.
- R10: Each received word is presented on `rx_word`, right-justified, with a one-cycle `rx_push` on the cycle after its final sample. If `rx_full` was 1 at the final sample, the push is dropped.
- R11: `busy` rises together with the first fall of `sel_n`, stays 1 for the whole stream including the phase-0 gaps, and falls when `sel_n` returns to idle with no word waiting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Permits new frames to start |
| clk_pol | input | 1 | Rest level of the serial clock |
| clk_pha | input | 1 | 0: sample on leading edge; 1: sample on trailing edge |
| len_m1 | input | 4 | Word length minus one (3..15) |
| half_div | input | 8 | Half period of the serial clock minus one, in system clocks |
| tx_avail | input | 1 | Transmit queue holds a word |
| tx_word | input | 16 | Head word of the transmit queue |
| tx_pop | output | 1 | One-cycle pop of the transmit queue |
| rx_full | input | 1 | Receive queue cannot accept a word |
| rx_push | output | 1 | One-cycle write of the receive queue |
| rx_word | output | 16 | Received word, right-justified |
| sdi | input | 1 | Serial data from the slave |
| sck | output | 1 | Serial clock |
| sel_n | output | 1 | Active-low frame select |
| sdo | output | 1 | Serial data to the slave |
| busy | output | 1 | Stream in progress |

## Verification
On every cycle, the assertions check these properties: each pop is a single-cycle pulse that follows an enabled, non-empty queue; a receive push is never issued into a full queue; `busy` covers every low period of `sel_n`; `sck` never toggles while frame select is high during a stream; frame select rises only with the clock at rest; and clock ticks are never adjacent. Other behaviour can only be shown by the bench scenarios, which use a behavioural slave: the exact cycle distances from select fall to the first data bit and the first edge, the width of the phase-0 gap, the release delay after the last sample, the sampling edge in each polarity and phase, the clamping of length and divider, and bit-exact data in both directions.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SETUP,
        ST_BITS,
        ST_TAIL,
        ST_GAP
    } seq_state_e;
endpackage

// File: rtl/spi_half_tick.sv
module spi_half_tick #(
    parameter int DIVW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [DIVW-1:0] div_i,
    output logic            tick_o
);
    typedef struct packed {
        logic [DIVW-1:0] cnt;
    } tick_t;

    tick_t tk_d, tk_q;

    assign tick_o = run && (tk_q.cnt == div_i);

    always_comb begin
        tk_d = tk_q;
        if (!run || tick_o) begin
            tk_d.cnt = '0;
        end else begin
            tk_d.cnt = tk_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tk_q <= '0;
        end else begin
            tk_q <= tk_d;
        end
    end

    AST_TICK_NOT_ADJACENT: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o); // R9
endmodule

// File: rtl/spi_shift_unit.sv
module spi_shift_unit #(
    parameter int MAXW = 16,
    parameter int LW   = $clog2(MAXW)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [MAXW-1:0] ld_word,
    input  logic [LW-1:0]   ld_len,
    input  logic            shift,
    input  logic            sample,
    input  logic            capture,
    input  logic            sdi,
    input  logic            rx_full,
    output logic            tx_msb,
    output logic [MAXW-1:0] rx_word,
    output logic            rx_push
);
    typedef struct packed {
        logic [MAXW-1:0] tx;
        logic [MAXW-1:0] rx;
        logic [MAXW-1:0] word;
        logic            push;
    } shf_t;

    shf_t sh_d, sh_q;
    logic [LW-1:0] align;

    assign tx_msb  = sh_q.tx[MAXW-1];
    assign rx_word = sh_q.word;
    assign rx_push = sh_q.push;

    always_comb begin
        sh_d      = sh_q;
        sh_d.push = 1'b0;
        align     = LW'(MAXW - 1) - ld_len;
        if (shift) begin
            sh_d.tx = {sh_q.tx[MAXW-2:0], 1'b0};
        end
        if (sample) begin
            sh_d.rx = {sh_q.rx[MAXW-2:0], sdi};
        end
        if (capture) begin
            sh_d.word = {sh_q.rx[MAXW-2:0], sdi};
            sh_d.push = !rx_full;
        end
        if (load) begin
            sh_d.tx = ld_word << align;
            sh_d.rx = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    AST_PUSH_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> !$past(rx_full)); // R10
    AST_PUSH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |=> !rx_push); // R10
endmodule

// File: rtl/spi_frame_ctl.sv
module spi_frame_ctl
    import spi_seq_pkg::*;
#(
    parameter int MAXW = 16,
    parameter int DIVW = 8,
    parameter int LW   = $clog2(MAXW)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable,
    input  logic            cfg_pol,
    input  logic            cfg_pha,
    input  logic [LW-1:0]   cfg_len,
    input  logic [DIVW-1:0] cfg_div,
    input  logic            tx_avail,
    input  logic            tick,
    input  logic            tx_msb,
    output logic            run,
    output logic [DIVW-1:0] div_o,
    output logic [LW-1:0]   ld_len,
    output logic            load,
    output logic            shift,
    output logic            sample,
    output logic            capture,
    output logic            sck,
    output logic            sel_n,
    output logic            sdo,
    output logic            busy,
    output logic            tx_pop
);
    typedef struct packed {
        seq_state_e      state;
        logic            sck;
        logic            sel_n;
        logic            sdo;
        logic            busy;
        logic            pop;
        logic            pol;
        logic            pha;
        logic [LW-1:0]   len;
        logic [DIVW-1:0] div;
        logic [LW:0]     edge_n;
        logic            hcnt;
    } ctl_t;

    ctl_t c_d, c_q;

    logic [LW-1:0]   len_in;
    logic [DIVW-1:0] div_in;
    logic [LW:0]     e_idx;
    logic [LW:0]     last_e;
    logic [LW:0]     last_s;
    logic            lead;
    logic            want;

    assign run    = (c_q.state != ST_IDLE);
    assign div_o  = c_q.div;
    assign ld_len = (c_q.state == ST_IDLE) ? len_in : c_q.len;
    assign sck    = c_q.sck;
    assign sel_n  = c_q.sel_n;
    assign sdo    = c_q.sdo;
    assign busy   = c_q.busy;
    assign tx_pop = c_q.pop;

    always_comb begin
        c_d     = c_q;
        c_d.pop = 1'b0;
        load    = 1'b0;
        shift   = 1'b0;
        sample  = 1'b0;
        capture = 1'b0;
        len_in  = (cfg_len < LW'(3)) ? LW'(3) : cfg_len;
        div_in  = (cfg_div == '0) ? DIVW'(1) : cfg_div;
        e_idx   = (c_q.state == ST_SETUP) ? '0 : c_q.edge_n;
        lead    = ~e_idx[0];
        last_e  = {c_q.len, 1'b1};
        last_s  = {c_q.len, c_q.pha};
        want    = enable && tx_avail;

        case (c_q.state)
            ST_IDLE: begin
                c_d.sck    = cfg_pol;
                c_d.sel_n  = 1'b1;
                c_d.sdo    = 1'b0;
                c_d.busy   = 1'b0;
                c_d.pol    = cfg_pol;
                c_d.pha    = cfg_pha;
                c_d.len    = len_in;
                c_d.div    = div_in;
                c_d.edge_n = '0;
                c_d.hcnt   = 1'b0;
                if (want) begin
                    c_d.pop   = 1'b1;
                    load      = 1'b1;
                    c_d.sel_n = 1'b0;
                    c_d.busy  = 1'b1;
                    c_d.state = ST_LEAD;
                end
            end
            ST_LEAD: begin
                if (tick) begin
                    if (!c_q.pha) begin
                        c_d.sdo = tx_msb;
                        shift   = 1'b1;
                    end
                    c_d.state = ST_SETUP;
                end
            end
            ST_SETUP, ST_BITS: begin
                if (tick) begin
                    c_d.sck = ~c_q.sck;
                    if (c_q.pha ? lead : (!lead && (e_idx != last_e))) begin
                        c_d.sdo = tx_msb;
                        shift   = 1'b1;
                    end
                    if (c_q.pha ? !lead : lead) begin
                        sample = 1'b1;
                        if (e_idx == last_s) begin
                            capture = 1'b1;
                        end
                    end
                    if (e_idx == last_e) begin
                        if (c_q.pha && want) begin
                            c_d.pop    = 1'b1;
                            load       = 1'b1;
                            c_d.edge_n = '0;
                            c_d.state  = ST_BITS;
                        end else begin
                            c_d.hcnt  = 1'b0;
                            c_d.state = ST_TAIL;
                        end
                    end else begin
                        c_d.edge_n = e_idx + 1'b1;
                        c_d.state  = ST_BITS;
                    end
                end
            end
            ST_TAIL: begin
                if (tick) begin
                    if (!c_q.pha || c_q.hcnt) begin
                        c_d.sel_n = 1'b1;
                        c_d.sdo   = 1'b0;
                        c_d.hcnt  = 1'b0;
                        if (!c_q.pha && want) begin
                            c_d.state = ST_GAP;
                        end else begin
                            c_d.busy  = 1'b0;
                            c_d.state = ST_IDLE;
                        end
                    end else begin
                        c_d.hcnt = 1'b1;
                    end
                end
            end
            ST_GAP: begin
                if (tick) begin
                    if (c_q.hcnt) begin
                        c_d.hcnt = 1'b0;
                        if (want) begin
                            c_d.pop   = 1'b1;
                            load      = 1'b1;
                            c_d.sel_n = 1'b0;
                            c_d.state = ST_LEAD;
                        end else begin
                            c_d.busy  = 1'b0;
                            c_d.state = ST_IDLE;
                        end
                    end else begin
                        c_d.hcnt = 1'b1;
                    end
                end
            end
            default: c_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q        <= '0;
            c_q.state  <= ST_IDLE;
            c_q.sel_n  <= 1'b1;
            c_q.div    <= DIVW'(1);
            c_q.len    <= LW'(3);
        end else begin
            c_q <= c_d;
        end
    end

    AST_POP_NEEDS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.pop |-> $past(enable && tx_avail)); // R2
    AST_POP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.pop |=> !c_q.pop); // R2
    AST_BUSY_COVERS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        !c_q.sel_n |-> c_q.busy); // R11
    AST_NO_EDGE_WHILE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.busy && $past(c_q.busy) && (c_q.sck != $past(c_q.sck))) |-> !c_q.sel_n); // R4
    AST_RELEASE_AT_REST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(c_q.sel_n) |-> (c_q.sck == c_q.pol)); // R5
endmodule

// File: rtl/spi_frame_seq.sv
module spi_frame_seq #(
    parameter int MAX_BITS = 16,
    parameter int DIV_W    = 8,
    parameter int LEN_W    = $clog2(MAX_BITS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic                clk_pol,
    input  logic                clk_pha,
    input  logic [LEN_W-1:0]    len_m1,
    input  logic [DIV_W-1:0]    half_div,
    input  logic                tx_avail,
    input  logic [MAX_BITS-1:0] tx_word,
    output logic                tx_pop,
    input  logic                rx_full,
    output logic                rx_push,
    output logic [MAX_BITS-1:0] rx_word,
    input  logic                sdi,
    output logic                sck,
    output logic                sel_n,
    output logic                sdo,
    output logic                busy
);
    logic             run;
    logic             tick;
    logic [DIV_W-1:0] div_cur;
    logic [LEN_W-1:0] ld_len;
    logic             load;
    logic             shift;
    logic             sample;
    logic             capture;
    logic             tx_msb;

    spi_half_tick #(.DIVW(DIV_W)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .div_i  (div_cur),
        .tick_o (tick)
    );

    spi_frame_ctl #(.MAXW(MAX_BITS), .DIVW(DIV_W), .LW(LEN_W)) u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .cfg_pol  (clk_pol),
        .cfg_pha  (clk_pha),
        .cfg_len  (len_m1),
        .cfg_div  (half_div),
        .tx_avail (tx_avail),
        .tick     (tick),
        .tx_msb   (tx_msb),
        .run      (run),
        .div_o    (div_cur),
        .ld_len   (ld_len),
        .load     (load),
        .shift    (shift),
        .sample   (sample),
        .capture  (capture),
        .sck      (sck),
        .sel_n    (sel_n),
        .sdo      (sdo),
        .busy     (busy),
        .tx_pop   (tx_pop)
    );

    spi_shift_unit #(.MAXW(MAX_BITS), .LW(LEN_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .ld_word (tx_word),
        .ld_len  (ld_len),
        .shift   (shift),
        .sample  (sample),
        .capture (capture),
        .sdi     (sdi),
        .rx_full (rx_full),
        .tx_msb  (tx_msb),
        .rx_word (rx_word),
        .rx_push (rx_push)
    );
endmodule

// File: tb/spi_frame_seq_bench.sv
module spi_frame_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        cpol = 1'b0;
    logic        cpha = 1'b0;
    logic [3:0]  len_m1 = 4'd7;
    logic [7:0]  half_div = 8'd1;
    logic        tx_avail;
    logic [15:0] tx_word;
    logic        tx_pop;
    logic        rx_full = 1'b0;
    logic        rx_push;
    logic [15:0] rx_word;
    logic        miso_r = 1'b0;
    logic        sck, sel_n, sdo, busy;

    always #4 clk = ~clk;

    spi_frame_seq u_spi_frame_seq (
        .clk(clk), .rst_n(rst_n), .enable(enable), .clk_pol(cpol), .clk_pha(cpha),
        .len_m1(len_m1), .half_div(half_div), .tx_avail(tx_avail), .tx_word(tx_word),
        .tx_pop(tx_pop), .rx_full(rx_full), .rx_push(rx_push), .rx_word(rx_word),
        .sdi(miso_r), .sck(sck), .sel_n(sel_n), .sdo(sdo), .busy(busy)
    );

    // transmit queue model
    logic [15:0] txq [0:15];
    int th = 0;
    int tt = 0;
    assign tx_avail = (th != tt);
    assign tx_word  = txq[th[3:0]];
    always @(posedge clk) if (tx_pop) th <= th + 1;

    // receive queue model
    logic [15:0] rxg [0:31];
    int rn = 0;
    always @(posedge clk) if (rx_push) begin rxg[rn[4:0]] <= rx_word; rn <= rn + 1; end

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // slave model and timing monitor
    logic [15:0] sw [0:15];
    logic [15:0] sgot [0:15];
    int nb = 8, hexp = 2;
    bit clr_req = 0;
    int nfall, nrise, t_fall, t_fall0, t_rise, t_mosi, t_edge1, t_prev, t_last;
    int nedge, ivbad, bbad, gmin, gmax, sidx, bits, shc, ldc;
    logic dir1, pfss, psclk, pmosi, lead;
    logic [15:0] rxsh;

    always @(negedge clk) begin
        if (clr_req) begin
            nfall = 0; nrise = 0; t_fall = -1; t_fall0 = -1; t_rise = -1; t_mosi = -1;
            t_edge1 = -1; t_prev = -1; t_last = -1; nedge = 0; ivbad = 0; bbad = 0;
            gmin = 1000000; gmax = -1; sidx = 0; bits = 0; shc = 0; ldc = 0; rxsh = 0;
            dir1 = 1'b0;
        end else begin
            if (pfss && !sel_n) begin
                nfall++;
                if (t_fall0 < 0) t_fall0 = cyc;
                if (t_rise >= 0) begin
                    if (cyc - t_rise < gmin) gmin = cyc - t_rise;
                    if (cyc - t_rise > gmax) gmax = cyc - t_rise;
                end
                t_fall = cyc; t_prev = -1; shc = 0; bits = 0; ldc = 0; rxsh = 0;
                if (!busy) bbad++;
                if (!cpha) miso_r = sw[sidx][nb-1];
            end
            if (!pfss && sel_n) begin nrise++; t_rise = cyc; end
            if (!sel_n && (sdo != pmosi) && t_mosi < 0) t_mosi = cyc;
            if (!sel_n && (sck != psclk)) begin
                nedge++;
                if (t_edge1 < 0) begin t_edge1 = cyc; dir1 = sck; end
                if (t_prev >= 0 && (cyc - t_prev) != hexp) ivbad++;
                t_prev = cyc;
                lead = (sck != cpol);
                if (cpha ? !lead : lead) begin
                    rxsh = {rxsh[14:0], sdo};
                    bits++;
                    t_last = cyc;
                    if (bits == nb) begin
                        sgot[sidx] = rxsh; sidx++; bits = 0; rxsh = 0; ldc = 0;
                    end
                end else if (!cpha) begin
                    shc++;
                    if (shc < nb) miso_r = sw[sidx][nb-1-shc];
                end else begin
                    miso_r = sw[sidx][nb-1-ldc];
                    ldc++;
                end
            end
        end
        pfss = sel_n; psclk = sck; pmosi = sdo;
    end

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_stats();
        @(negedge clk); clr_req = 1;
        @(negedge clk); #1 clr_req = 0;
    endtask

    task automatic wait_done(string req);
        int n = 0;
        while (!busy && n < 20000) begin @(negedge clk); n++; end
        while (busy && n < 40000) begin @(negedge clk); n++; end
        check({req, " stream completes"}, (n < 40000) ? 1 : 0, 1);
        repeat (4) @(negedge clk);
    endtask

    // one stream of nw words in the given mode, with all checks on the result
    task automatic run_case(logic pol, logic pha, logic [3:0] lm1, logic [7:0] dv, int nw, logic full);
        int n, h, base;
        logic [15:0] mask;
        n = ((lm1 < 3) ? 3 : lm1) + 1;
        h = ((dv == 0) ? 1 : dv) + 1;
        mask = 16'((32'd1 << n) - 1);
        @(negedge clk);
        enable = 1'b0; cpol = pol; cpha = pha; len_m1 = lm1; half_div = dv; rx_full = full;
        nb = n; hexp = h;
        for (int i = 0; i < nw; i++) begin
            sw[i] = 16'h3C69 + 16'(i * 16'h2B17);
            txq[(tt + i) % 16] = 16'hA5C3 ^ 16'(i * 16'h1357);
        end
        txq[tt % 16][n-1] = 1'b1;
        clear_stats();
        base = rn;
        tt = tt + nw;
        @(negedge clk); enable = 1'b1;
        wait_done("R2");
        check("R1 idle sel_n", int'(sel_n), 1);
        check("R1 idle sck", int'(sck), int'(pol));
        check("R1 idle sdo", int'(sdo), 0);
        check("R11 busy at fall", bbad, 0);
        check("R11 busy end", int'(busy), 0);
        check("R7 edge count", nedge, 2 * n * nw);
        check("R9 edge spacing", ivbad, 0);
        check("R3 first edge delay", t_edge1 - t_fall0, 2 * h);
        check("R4 first edge direction", int'(dir1), int'(!pol));
        check("R5 release delay", t_rise - t_last, 2 * h);
        if (!pha) begin
            check("R3 MSB delay", t_mosi - t_fall0, h);
            check("R6 frames", nfall, nw);
            if (nw > 1) begin
                check("R6 gap min", gmin, 2 * h);
                check("R6 gap max", gmax, 2 * h);
            end
        end else begin
            check("R8 single fall", nfall, 1);
            check("R8 single rise", nrise, 1);
        end
        for (int i = 0; i < nw; i++) begin
            check("R4 R7 slave got word", int'(sgot[i]), int'(txq[(tt - nw + i) % 16] & mask));
            if (!full) check("R10 rx word", int'(rxg[(base + i) % 32]), int'(sw[i] & mask));
        end
        check("R10 push count", rn - base, full ? 0 : nw);
        @(negedge clk); enable = 1'b0; rx_full = 1'b0;
    endtask

    task automatic test_reset();
        @(negedge clk); cpol = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 reset sck", int'(sck), 1);
        check("R1 reset sel_n", int'(sel_n), 1);
        check("R1 reset sdo", int'(sdo), 0);
        check("R1 reset busy", int'(busy), 0);
    endtask

    task automatic test_disabled();
        @(negedge clk); enable = 1'b0; cpol = 1'b0; cpha = 1'b0; len_m1 = 4'd7; half_div = 8'd1;
        nb = 8; hexp = 2;
        sw[0] = 16'h005A;
        txq[tt % 16] = 16'h00C3;
        clear_stats();
        tt = tt + 1;
        repeat (200) @(negedge clk);
        check("R2 no start while disabled", nfall, 0);
        check("R2 word not popped", tt - th, 1);
        check("R2 sel_n held", int'(sel_n), 1);
        enable = 1'b1;
        wait_done("R2");
        check("R2 word sent after enable", int'(sgot[0]), 16'h00C3);
        check("R2 word popped", tt - th, 0);
        @(negedge clk); enable = 1'b0;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        test_disabled();
        run_case(1'b0, 1'b0, 4'd7,  8'd1, 1, 1'b0);
        run_case(1'b1, 1'b0, 4'd11, 8'd3, 3, 1'b0);
        run_case(1'b1, 1'b1, 4'd15, 8'd2, 3, 1'b0);
        run_case(1'b0, 1'b1, 4'd0,  8'd0, 2, 1'b0);
        run_case(1'b1, 1'b0, 4'd3,  8'd2, 2, 1'b1);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
            $finish;
        end
    end
endmodule